// File: doc/BRIEF.md
# Vectored Interrupt Controller with Edge Select

This block arbitrates interrupt requests for a small 8-bit processor core. It watches four sources: one external pin, the overflow pulses of two timers and one aggregated request line that merges several slower peripherals. Each source has a pending flag and an enable bit, and a single master enable gates them all.

When the master enable is on, at least one enabled flag is pending and the core's return stack still has room, the block hands the core a vectored call. It raises a one-cycle acknowledge with the target address of the highest-priority pending source. On that same clock edge it drops the serviced flag and the master enable. Software sees every flag, enable and the master enable at the outputs, and can overwrite them through simple write strobes.

The external pin passes through a two-stage synchronizer. A two-bit mode selects which transitions count: none, rising only, falling only, or both. The pin only counts when the shared pad is set as an input and its enable bit is set.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, all flags, all enables, the master enable `gie` and `irq_ack` are 0.
- R2: The external trigger mode `ext_mode` is decoded as 00 = no trigger, 01 = rising edge, 10 = falling edge, 11 = either edge. A qualifying transition sets flag bit 0 on the third rising clock edge after the pin changes.
- R3: The external flag is set only while `pin_is_input` is 1 and enable bit 0 is 1. Otherwise a pin transition leaves flag bit 0 at 0.
- R4: A one-cycle high on `tmr_ovf[0]` sets flag bit 1, and on `tmr_ovf[1]` sets flag bit 2, at the next clock edge. A rising edge of `mf_req` sets flag bit 3, and holding `mf_req` high does not set the flag again after it is cleared.
- R5: A call is issued only when `gie` is 1, a flag and its matching enable are both 1, and `stack_full` is 0. While `stack_full` is 1, no acknowledge occurs and the flags are kept.
- R6: The vector addresses are 0x04 for the external source (bit 0), 0x08 for timer 0 (bit 1), 0x0C for timer 1 (bit 2) and 0x10 for the multi-function source (bit 3).
- R7: When several enabled flags are pending, the lowest flag bit is served first: external, then timer 0, then timer 1, then multi-function.
- R8: `irq_ack` is high for exactly one cycle, with `irq_vector` valid. On the edge that raises it, the served flag and `gie` are cleared, and the other flags are unchanged.
- R9: The write strobes work as follows. `wr_flags` loads `flags` from `wr_data`, `wr_enables` loads `enables` from `wr_data`, and `wr_gie` loads `gie` from `wr_data[0]`. A hardware flag set in the same cycle as a software clear of that flag leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin | input | 1 | External interrupt pin, asynchronous |
| pin_is_input | input | 1 | Shared pad configured as input |
| ext_mode | input | 2 | External trigger mode |
| tmr_ovf | input | 2 | Timer overflow pulses, bit n for timer n |
| mf_req | input | 1 | Aggregated multi-function request |
| stack_full | input | 1 | Core return stack has no free entry |
| wr_flags | input | 1 | Write strobe for the flag register |
| wr_enables | input | 1 | Write strobe for the enable register |
| wr_gie | input | 1 | Write strobe for the master enable |
| wr_data | input | 4 | Write data |
| flags | output | 4 | Pending flags |
| enables | output | 4 | Source enables |
| gie | output | 1 | Master interrupt enable |
| irq_ack | output | 1 | One-cycle call request to the core |
| irq_vector | output | 8 | Call target address |

## Verification
The assertions assume that software does not write `gie` or `flags` on the same edge as an acknowledge. The stimulus keeps all writes well apart from any cycle in which a call can fire, and holds `gie` at 0 during the flag-setting sweeps.

The acknowledge check on the external flag assumes the pin changes level only between clock edges. The bench changes `ext_pin` only on falling edges and waits for the synchronizer to settle before clearing flags. Priority and vector checks sweep all fifteen non-empty flag patterns with every enable set.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
   typedef enum logic [1:0] {
      TRIG_OFF  = 2'b00,
      TRIG_RISE = 2'b01,
      TRIG_FALL = 2'b10,
      TRIG_BOTH = 2'b11
   } trig_mode_e;
endpackage

// File: rtl/irq_pin_edge.sv
module irq_pin_edge #(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pin,
   input  logic [1:0] mode,
   input  logic       gate,
   output logic       hit
);
   import irq_ctrl_pkg::*;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("irq_pin_edge: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   lvl;
   logic                   rise, fall;
   trig_mode_e             sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
         prev_q <= sync_q[SYNC_STAGES-1];
      end
   end

   assign lvl  = sync_q[SYNC_STAGES-1];
   assign rise = lvl & ~prev_q;
   assign fall = ~lvl & prev_q;
   assign sel  = trig_mode_e'(mode);

   always_comb begin
      unique case (sel)
         TRIG_RISE: hit = gate & rise;
         TRIG_FALL: hit = gate & fall;
         TRIG_BOTH: hit = gate & (rise | fall);
         default:   hit = 1'b0;
      endcase
   end
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
   parameter int NUM_SRC = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] hw_set,
   input  logic [NUM_SRC-1:0] svc_clr,
   input  logic               svc_fire,
   input  logic               wr_flags,
   input  logic               wr_enables,
   input  logic               wr_gie,
   input  logic [NUM_SRC-1:0] wr_data,
   output logic [NUM_SRC-1:0] flags,
   output logic [NUM_SRC-1:0] enables,
   output logic               gie
);
   logic [NUM_SRC-1:0] flags_d;
   logic               gie_d;

   always_comb begin
      flags_d = wr_flags ? wr_data : flags;
      flags_d = (flags_d & ~svc_clr) | hw_set;
      gie_d   = wr_gie ? wr_data[0] : gie;
      if (svc_fire) gie_d = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags   <= '0;
         enables <= '0;
         gie     <= 1'b0;
      end else begin
         flags <= flags_d;
         gie   <= gie_d;
         if (wr_enables) enables <= wr_data;
      end
   end

   assert_hw_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (|hw_set) |=> ((flags & $past(hw_set)) == $past(hw_set)));

   assert_svc_drops_gie_R8: assert property (@(posedge clk) disable iff (!rst_n)
      svc_fire |=> !gie);
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb #(
   parameter int NUM_SRC  = 4,
   parameter int VEC_W    = 8,
   parameter int VEC_BASE = 4,
   parameter int VEC_STEP = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] pending,
   input  logic               gie,
   input  logic               stack_full,
   output logic [NUM_SRC-1:0] grant,
   output logic               fire,
   output logic               ack_q,
   output logic [VEC_W-1:0]   vec_q
);
   localparam int VEC_TOP = VEC_BASE + VEC_STEP * (NUM_SRC - 1);

   generate
      if (VEC_TOP >= (1 << VEC_W)) begin : g_bad_vec
         $error("irq_prio_arb: vector table does not fit VEC_W");
      end
   endgenerate

   logic [VEC_W-1:0] vec_d;

   always_comb begin
      grant = '0;
      vec_d = '0;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
         if (pending[i]) begin
            grant = '0;
            grant[i] = 1'b1;
            vec_d = VEC_W'(VEC_BASE + VEC_STEP * i);
         end
      end
   end

   assign fire = gie & ~stack_full & (|pending);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_q <= 1'b0;
         vec_q <= '0;
      end else begin
         ack_q <= fire;
         if (fire) vec_q <= vec_d;
      end
   end

   assert_single_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   assert_ack_conditions_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ack_q |-> ($past(gie) && !$past(stack_full) && ($past(pending) != '0)));

   assert_ack_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ack_q |=> !ack_q);
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
   parameter int NUM_TMR     = 2,
   parameter int SYNC_STAGES = 2,
   parameter int VEC_W       = 8,
   parameter int VEC_BASE    = 4,
   parameter int VEC_STEP    = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ext_pin,
   input  logic                 pin_is_input,
   input  logic [1:0]           ext_mode,
   input  logic [NUM_TMR-1:0]   tmr_ovf,
   input  logic                 mf_req,
   input  logic                 stack_full,
   input  logic                 wr_flags,
   input  logic                 wr_enables,
   input  logic                 wr_gie,
   input  logic [NUM_TMR+1:0]   wr_data,
   output logic [NUM_TMR+1:0]   flags,
   output logic [NUM_TMR+1:0]   enables,
   output logic                 gie,
   output logic                 irq_ack,
   output logic [VEC_W-1:0]     irq_vector
);
   localparam int NUM_SRC = NUM_TMR + 2;
   localparam int MF_IDX  = NUM_SRC - 1;

   generate
      if (NUM_TMR < 1) begin : g_bad_tmr
         $error("irq_vector_ctrl: NUM_TMR must be at least 1");
      end
   endgenerate

   logic [NUM_SRC-1:0] hw_set;
   logic [NUM_SRC-1:0] grant;
   logic               fire;
   logic               ext_hit;
   logic               mf_prev_q;

   irq_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .pin  (ext_pin),
      .mode (ext_mode),
      .gate (pin_is_input & enables[0]),
      .hit  (ext_hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mf_prev_q <= 1'b0;
      else        mf_prev_q <= mf_req;
   end

   assign hw_set[0]      = ext_hit;
   assign hw_set[MF_IDX] = mf_req & ~mf_prev_q;

   genvar g;
   generate
      for (g = 0; g < NUM_TMR; g++) begin : g_tmr
         assign hw_set[1+g] = tmr_ovf[g];
      end
   endgenerate

   irq_flag_bank #(.NUM_SRC(NUM_SRC)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .hw_set    (hw_set),
      .svc_clr   (fire ? grant : '0),
      .svc_fire  (fire),
      .wr_flags  (wr_flags),
      .wr_enables(wr_enables),
      .wr_gie    (wr_gie),
      .wr_data   (wr_data),
      .flags     (flags),
      .enables   (enables),
      .gie       (gie)
   );

   irq_prio_arb #(
      .NUM_SRC (NUM_SRC),
      .VEC_W   (VEC_W),
      .VEC_BASE(VEC_BASE),
      .VEC_STEP(VEC_STEP)
   ) u_arb (
      .clk       (clk),
      .rst_n     (rst_n),
      .pending   (flags & enables),
      .gie       (gie),
      .stack_full(stack_full),
      .grant     (grant),
      .fire      (fire),
      .ack_q     (irq_ack),
      .vec_q     (irq_vector)
   );

   assert_ext_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(flags[0]) && !$past(wr_flags)) |->
         ($past(pin_is_input) && $past(enables[0]) && ($past(ext_mode) != 2'b00)));

   assert_ack_clears_gie_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack |-> !gie);

   assert_vector_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack |-> ((irq_vector >= VEC_W'(VEC_BASE)) &&
                   (irq_vector <= VEC_W'(VEC_BASE + VEC_STEP * MF_IDX))));
endmodule

// File: tb/test_irq_vector_ctrl.sv
module test_irq_vector_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ext_pin = 1'b0;
   logic       pin_is_input = 1'b0;
   logic [1:0] ext_mode = 2'b00;
   logic [1:0] tmr_ovf = 2'b00;
   logic       mf_req = 1'b0;
   logic       stack_full = 1'b0;
   logic       wr_flags = 1'b0;
   logic       wr_enables = 1'b0;
   logic       wr_gie = 1'b0;
   logic [3:0] wr_data = 4'h0;
   logic [3:0] flags;
   logic [3:0] enables;
   logic       gie;
   logic       irq_ack;
   logic [7:0] irq_vector;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   irq_vector_ctrl i_irq_vector_ctrl (
      .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .pin_is_input(pin_is_input),
      .ext_mode(ext_mode), .tmr_ovf(tmr_ovf), .mf_req(mf_req),
      .stack_full(stack_full), .wr_flags(wr_flags), .wr_enables(wr_enables),
      .wr_gie(wr_gie), .wr_data(wr_data), .flags(flags), .enables(enables),
      .gie(gie), .irq_ack(irq_ack), .irq_vector(irq_vector)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr(input logic f, input logic e, input logic g, input logic [3:0] d);
      wr_flags = f; wr_enables = e; wr_gie = g; wr_data = d;
      @(negedge clk);
      wr_flags = 0; wr_enables = 0; wr_gie = 0; wr_data = 0;
   endtask

   initial begin
      #(200000 * 10);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      cyc(2);
      rst_n = 1'b1;
      cyc(1);
      // R1 reset state
      chk("R1 flags", flags, 0);
      chk("R1 enables", enables, 0);
      chk("R1 gie", gie, 0);
      chk("R1 ack", irq_ack, 0);

      // R2 / R3 external edge sweep, gie kept at 0
      for (int m = 0; m < 4; m++)
         for (int d = 0; d < 2; d++)
            for (int pi = 0; pi < 2; pi++)
               for (int en = 0; en < 2; en++) begin
                  bit rising, expf;
                  rising = (d == 0);
                  ext_mode = 2'(m);
                  pin_is_input = 1'(pi);
                  wr(0, 1, 0, {3'b000, 1'(en)});
                  ext_pin = ~rising;
                  cyc(4);
                  wr(1, 0, 0, 4'h0);
                  ext_pin = rising;
                  cyc(3);
                  expf = (pi == 1) && (en == 1) &&
                         ((m == 1 && rising) || (m == 2 && !rising) || m == 3);
                  chk(pi == 1 && en == 1 ? "R2 ext edge mode" : "R3 ext gating",
                      flags[0], int'(expf));
               end
      pin_is_input = 0;
      ext_mode = 2'b00;
      wr(1, 1, 0, 4'h0);

      // R4 timer pulses and multi-function edge
      for (int t = 0; t < 2; t++) begin
         tmr_ovf[t] = 1'b1;
         cyc(1);
         tmr_ovf[t] = 1'b0;
         chk("R4 timer flag", flags, 1 << (t + 1));
         wr(1, 0, 0, 4'h0);
      end
      mf_req = 1'b1;
      cyc(1);
      chk("R4 mf flag set", flags, 4'h8);
      wr(1, 0, 0, 4'h0);
      cyc(2);
      chk("R4 mf level no reset", flags, 4'h0);
      mf_req = 1'b0;
      cyc(1);

      // R6 / R7 / R8 all non-empty flag patterns
      wr(0, 1, 0, 4'hF);
      for (int s = 1; s < 16; s++) begin
         int lo;
         lo = 0;
         while (((s >> lo) & 1) == 0) lo++;
         wr(1, 0, 0, 4'(s));
         wr(0, 0, 1, 4'h1);
         cyc(1);
         chk("R8 ack high", irq_ack, 1);
         chk("R6 R7 vector", irq_vector, 4 + 4 * lo);
         chk("R8 flag cleared", flags, s & ~(1 << lo));
         chk("R8 gie cleared", gie, 0);
         cyc(1);
         chk("R8 ack one cycle", irq_ack, 0);
         wr(1, 0, 0, 4'h0);
      end

      // R5 stack full blocks, then releases
      stack_full = 1'b1;
      wr(1, 0, 0, 4'h4);
      wr(0, 0, 1, 4'h1);
      cyc(3);
      chk("R5 stack full no ack", irq_ack, 0);
      chk("R5 flags kept", flags, 4'h4);
      chk("R5 gie kept", gie, 1);
      stack_full = 1'b0;
      cyc(1);
      chk("R5 ack after release", irq_ack, 1);
      chk("R6 timer1 vector", irq_vector, 8'h0C);
      cyc(1);

      // R5 source enable gating
      wr(0, 1, 0, 4'b1011);
      wr(1, 0, 0, 4'h4);
      wr(0, 0, 1, 4'h1);
      cyc(3);
      chk("R5 disabled source no ack", irq_ack, 0);
      chk("R5 disabled flag kept", flags, 4'h4);
      wr(0, 0, 1, 4'h0);
      wr(1, 0, 0, 4'h0);

      // R9 hardware set beats software clear
      wr(1, 0, 0, 4'h2);
      tmr_ovf[0] = 1'b1;
      wr(1, 0, 0, 4'h0);
      tmr_ovf[0] = 1'b0;
      chk("R9 hw set wins", flags, 4'h2);
      wr(1, 0, 0, 4'h9);
      chk("R9 sw flag write", flags, 4'h9);
      chk("R9 enables write", enables, 4'hB);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule